// File: doc/BRIEF.md
# Teletext Display Window Timing

This block turns the horizontal clock count and the frame line number coming from the sync generator into the position of the beam inside a 25-row by 40-column text page. For every clock it reports whether the beam is inside the text window. It also reports which character column and which text row are being scanned, and which scan line of the character cell is being drawn. The page memory and the character generator downstream use these values as their address.

Two controls reshape the vertical mapping. One moves the status row (row 24) to the top of the window or to the bottom. The other selects double height: one half of the main text area (rows 0–11 or rows 12–23) is stretched over the whole main area, and each source row then covers 20 display lines. The status row is always drawn at normal height. All outputs are registered and appear one clock after the counters that produce them. Outside the window the enable is low and the position outputs keep their last values.

Top module: `ttx_disp_window`

## Requirements
- R1: While rst_ni is low, de_o, col_o, row_o and scan_o are all 0.
- R2: Each output reflects the inputs sampled on the previous rising clock edge. Horizontally the window covers hcnt_i values 100 to 339 inclusive (240 clocks). In that range col_o = (hcnt_i − 100) / 6, which runs from 0 to 39.
- R3: Vertically the window covers line_i 42 to 291 inclusive. It also covers lines 355 to 604 inclusive, but only when interlace_i = 1. Within a field the window line index w is line_i minus the first line of that field (42 or 355).
- R4: With status_top_i = 0 and normal height (dh_mode_i[0] = 0), slot = w / 10 and scan_o = w mod 10. Slots 0–23 give row_o = slot, and slot 24 gives row_o = 24 (the status row).
- R5: With status_top_i = 1, slot 0 is the status row (row_o = 24). Every other slot k gives row_o = k − 1 at normal height.
- R6: dh_mode_i[0] = 1 selects double height, and dh_mode_i[1] picks the half: 0 for rows 0–11, 1 for rows 12–23. The main line index m is w, or w − 10 when the status row is on top. For a main-area line, row_o = base + m / 20 and scan_o = (m mod 20) / 2, where base is 0 or 12.
- R7: In double-height mode with dh_mode_i = 2'b11, every main-area line shows a row from 12 to 23.
- R8: The status row is drawn at normal height in every height mode, with scan_o = w mod 10 on its ten lines.
- R9: When the sampled position is outside the window, de_o is 0 and col_o, row_o and scan_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display clock (one tick per character dot) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hcnt_i | input | 9 | Clock count since the leading edge of line sync |
| line_i | input | 10 | Frame line number from the sync generator |
| interlace_i | input | 1 | Enables the second-field window |
| status_top_i | input | 1 | 1: status row before the main area, 0: after it |
| dh_mode_i | input | 2 | Bit 0 enables double height, bit 1 selects the lower half |
| de_o | output | 1 | Display enable, high inside the text window |
| col_o | output | 6 | Character column 0–39 |
| row_o | output | 5 | Text row 0–24 (24 is the status row) |
| scan_o | output | 4 | Scan line within the character cell, 0–9 |

## Verification
The bound checker watches, on every cycle, properties that hold no matter which position is sampled. It confirms that the enable only rises for counter values inside the horizontal and vertical window. It confirms that the column stays below 40 and that the status row never shows a scan line above 9. It confirms that the position outputs do not move while the enable is low, and that each double-height half only ever shows rows from its own half. The exact arithmetic, by contrast, can only be shown by the bench's chosen positions at the window edges and at the slot and half boundaries. That arithmetic covers which row and scan line a given line maps to, the swap of the status slot, the second field depending on interlace, and the 240-clock width of a line.

// File: rtl/ttx_win_pkg.sv
package ttx_win_pkg;
  localparam int COLS     = 40;
  localparam int ROWS     = 25;
  localparam int CHAR_W   = 6;
  localparam int CELL_H   = 10;
  localparam int HCNT_W   = 9;
  localparam int LINE_W   = 10;
  localparam int COL_W    = $clog2(COLS);
  localparam int ROW_W    = $clog2(ROWS);
  localparam int SCAN_W   = $clog2(CELL_H);
  localparam int STAT_ROW = ROWS - 1;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [SCAN_W-1:0] scan;
  } disp_pos_t;
endpackage

// File: rtl/ttx_hwin.sv
module ttx_hwin
  import ttx_win_pkg::*;
#(
  parameter int H_START = 100
) (
  input  logic [HCNT_W-1:0] hcnt_i,
  output logic              h_act_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [HCNT_W-1:0] HS   = HCNT_W'(H_START);
  localparam logic [HCNT_W-1:0] HE   = HCNT_W'(H_START + COLS * CHAR_W);
  localparam logic [HCNT_W-1:0] CW_L = HCNT_W'(CHAR_W);

  logic [HCNT_W-1:0] off;

  assign h_act_o = (hcnt_i >= HS) && (hcnt_i < HE);
  assign off     = hcnt_i - HS;
  assign col_o   = COL_W'(off / CW_L);
endmodule

// File: rtl/ttx_vwin.sv
module ttx_vwin
  import ttx_win_pkg::*;
#(
  parameter int V_START_F0 = 42,
  parameter int V_START_F1 = 355
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              interlace_i,
  input  logic              status_top_i,
  input  logic [1:0]        dh_mode_i,
  output logic              v_act_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [SCAN_W-1:0] scan_o
);
  localparam logic [LINE_W-1:0] V0   = LINE_W'(V_START_F0);
  localparam logic [LINE_W-1:0] V1   = LINE_W'(V_START_F1);
  localparam logic [LINE_W-1:0] WIN  = LINE_W'(ROWS * CELL_H);
  localparam logic [LINE_W-1:0] CH   = LINE_W'(CELL_H);
  localparam logic [LINE_W-1:0] CH2  = LINE_W'(2 * CELL_H);
  localparam logic [LINE_W-1:0] HALF = LINE_W'((ROWS - 1) / 2);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(STAT_ROW);

  logic              in_f0, in_f1, is_stat;
  logic [LINE_W-1:0] wl, slot, ml, base;

  assign in_f0   = (line_i >= V0) && (line_i < V0 + WIN);
  assign in_f1   = interlace_i && (line_i >= V1) && (line_i < V1 + WIN);
  assign v_act_o = in_f0 || in_f1;

  assign wl      = in_f1 ? (line_i - V1) : (line_i - V0);
  assign slot    = wl / CH;
  assign is_stat = status_top_i ? (slot == '0) : (slot == LAST);
  assign ml      = status_top_i ? (wl - CH) : wl;
  assign base    = dh_mode_i[1] ? HALF : '0;

  always_comb begin
    if (is_stat) begin
      row_o  = ROW_W'(STAT_ROW);
      scan_o = SCAN_W'(wl % CH);
    end else if (dh_mode_i[0]) begin
      row_o  = ROW_W'(base + ml / CH2);
      scan_o = SCAN_W'((ml % CH2) >> 1);
    end else begin
      row_o  = ROW_W'(ml / CH);
      scan_o = SCAN_W'(wl % CH);
    end
  end
endmodule

// File: rtl/ttx_disp_window.sv
module ttx_disp_window
  import ttx_win_pkg::*;
#(
  parameter int H_START    = 100,
  parameter int V_START_F0 = 42,
  parameter int V_START_F1 = 355
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HCNT_W-1:0] hcnt_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              interlace_i,
  input  logic              status_top_i,
  input  logic [1:0]        dh_mode_i,
  output logic              de_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [SCAN_W-1:0] scan_o
);
  logic      h_act, v_act;
  disp_pos_t nxt, pos_q;
  logic      de_q;

  ttx_hwin #(.H_START(H_START)) u_hwin (
    .hcnt_i (hcnt_i),
    .h_act_o(h_act),
    .col_o  (nxt.col)
  );

  ttx_vwin #(.V_START_F0(V_START_F0), .V_START_F1(V_START_F1)) u_vwin (
    .line_i      (line_i),
    .interlace_i (interlace_i),
    .status_top_i(status_top_i),
    .dh_mode_i   (dh_mode_i),
    .v_act_o     (v_act),
    .row_o       (nxt.row),
    .scan_o      (nxt.scan)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q  <= 1'b0;
      pos_q <= '0;
    end else begin
      de_q <= h_act && v_act;
      if (h_act && v_act) pos_q <= nxt;  // hold position outside window
    end
  end

  assign de_o   = de_q;
  assign col_o  = pos_q.col;
  assign row_o  = pos_q.row;
  assign scan_o = pos_q.scan;
endmodule

// File: rtl/ttx_disp_window_chk.sv
module ttx_disp_window_chk
  import ttx_win_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HCNT_W-1:0] hcnt_i,
  input logic [LINE_W-1:0] line_i,
  input logic              interlace_i,
  input logic              status_top_i,
  input logic [1:0]        dh_mode_i,
  input logic              de_o,
  input logic [COL_W-1:0]  col_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [SCAN_W-1:0] scan_o
);
  AST_HWIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ($past(hcnt_i) >= 100 && $past(hcnt_i) < 340)); // R2
  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (col_o < COLS)); // R2
  AST_VWIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (($past(line_i) >= 42 && $past(line_i) <= 291) ||
              ($past(interlace_i) && $past(line_i) >= 355 && $past(line_i) <= 604))); // R3
  AST_STAT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(status_top_i) && $past(line_i) == 42) |-> (row_o == STAT_ROW)); // R5
  AST_DH_TOP_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(dh_mode_i) == 2'b01) |-> (row_o < 12 || row_o == STAT_ROW)); // R6
  AST_DH_BTM_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(dh_mode_i) == 2'b11) |-> (row_o >= 12)); // R7
  AST_STAT_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && row_o == STAT_ROW) |-> (scan_o < CELL_H)); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> ($stable(col_o) && $stable(row_o) && $stable(scan_o))); // R9
endmodule

bind ttx_disp_window ttx_disp_window_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hcnt_i      (hcnt_i),
  .line_i      (line_i),
  .interlace_i (interlace_i),
  .status_top_i(status_top_i),
  .dh_mode_i   (dh_mode_i),
  .de_o        (de_o),
  .col_o       (col_o),
  .row_o       (row_o),
  .scan_o      (scan_o)
);

// File: tb/ttx_disp_window_tb_top.sv
module ttx_disp_window_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] hcnt = '0;
  logic [9:0] line = '0;
  logic       il = 1'b0, top = 1'b0;
  logic [1:0] dh = 2'b00;
  logic       de;
  logic [5:0] col;
  logic [4:0] row;
  logic [3:0] scan;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ttx_disp_window dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .line_i(line),
    .interlace_i(il), .status_top_i(top), .dh_mode_i(dh),
    .de_o(de), .col_o(col), .row_o(row), .scan_o(scan)
  );

  // hcnt, line, il, top, dh, de, col, row, scan, req
  localparam int NV = 23;
  localparam int VEC [NV][10] = '{
    '{100, 42,0,0,0, 1, 0, 0,0, 2},  // R2 left edge
    '{339, 51,0,0,0, 1,39, 0,9, 2},  // R2 right edge
    '{340, 51,0,0,0, 0, 0, 0,0, 2},  // R2
    '{ 99, 42,0,0,0, 0, 0, 0,0, 2},  // R2
    '{160, 41,0,0,0, 0, 0, 0,0, 3},  // R3
    '{160, 52,0,0,0, 1,10, 1,0, 4},  // R4
    '{105,291,0,0,0, 1, 0,24,9, 4},  // R4 status at bottom
    '{105,292,0,0,0, 0, 0, 0,0, 3},  // R3
    '{105,360,0,0,0, 0, 0, 0,0, 3},  // R3 no second field
    '{106,360,1,0,0, 1, 1, 0,5, 3},  // R3
    '{100,604,1,0,0, 1, 0,24,9, 3},  // R3
    '{100,605,1,0,0, 0, 0, 0,0, 3},  // R3
    '{100, 42,0,1,0, 1, 0,24,0, 5},  // R5
    '{100, 52,0,1,0, 1, 0, 0,0, 5},  // R5
    '{100,291,0,1,0, 1, 0,23,9, 5},  // R5
    '{100, 67,0,0,1, 1, 0, 1,2, 6},  // R6
    '{100,281,0,0,1, 1, 0,11,9, 6},  // R6
    '{100, 42,0,0,3, 1, 0,12,0, 7},  // R7
    '{100, 44,0,0,3, 1, 0,12,1, 7},  // R7
    '{100,291,0,0,3, 1, 0,24,9, 8},  // R8
    '{100, 45,0,1,1, 1, 0,24,3, 8},  // R8
    '{100,291,0,1,1, 1, 0,11,9, 6},  // R6
    '{100, 67,0,0,2, 1, 0, 2,5, 4}   // R4 mode 2'b10 is normal
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int de_cnt, col_bad;
    // R1 reset state
    hcnt = 9'd150; line = 10'd100;
    repeat (3) @(negedge clk);
    chk("R1 de", de, 0); chk("R1 col", col, 0);
    chk("R1 row", row, 0); chk("R1 scan", scan, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      hcnt = 9'(VEC[i][0]); line = 10'(VEC[i][1]); il = VEC[i][2][0];
      top = VEC[i][3][0]; dh = 2'(VEC[i][4]);
      @(negedge clk);
      chk($sformatf("R%0d de v%0d", VEC[i][9], i), de, VEC[i][5]);
      if (VEC[i][5] == 1) begin
        chk($sformatf("R%0d col v%0d", VEC[i][9], i), col, VEC[i][6]);
        chk($sformatf("R%0d row v%0d", VEC[i][9], i), row, VEC[i][7]);
        chk($sformatf("R%0d scan v%0d", VEC[i][9], i), scan, VEC[i][8]);
      end
    end

    // R9 hold outside window
    @(negedge clk); hcnt = 9'd160; line = 10'd52; il = 0; top = 0; dh = 0;
    @(negedge clk); hcnt = 9'd20;
    @(negedge clk);
    chk("R9 de", de, 0); chk("R9 col", col, 10);
    chk("R9 row", row, 1); chk("R9 scan", scan, 0);
    hcnt = 9'd200; line = 10'd10;
    @(negedge clk);
    chk("R9 de vblank", de, 0); chk("R9 row vblank", row, 1);
    chk("R9 col vblank", col, 10);

    // R2 full line sweep on line 100 (w=58)
    de_cnt = 0; col_bad = 0; line = 10'd100;
    for (int h = 0; h <= 400; h++) begin
      @(negedge clk);
      if (h > 0 && de) begin
        de_cnt++;
        if (col != (h - 1 - 100) / 6 || row != 5 || scan != 8) col_bad++;
      end
      if (h < 400) hcnt = 9'(h);
    end
    chk("R2 line width", de_cnt, 240);
    chk("R2 sweep position errors", col_bad, 0);

    // R1 reset re-asserted mid run
    hcnt = 9'd150; line = 10'd100;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 re-reset de", de, 0); chk("R1 re-reset row", row, 0);
    rst_n = 1'b1;

    done = 1;
    finish_run();
  end
endmodule